// File: doc/BRIEF.md
# Per-Channel Gain Requantizer

This block sits between a channelizer and a packet formatter. Each cycle it can take one complex spectral sample for each of two polarizations, together with the number of the frequency channel the sample belongs to. It looks up a programmable gain for that channel, with a separate gain table for each polarization. It multiplies the real and imaginary parts by that gain and reduces each scaled part to a small signed code.

A single mode input picks the output width. In the wide mode each part becomes a 4-bit two's-complement code on a fixed 1/8 grid, rounded to nearest and clipped to 15 symmetric levels. In the narrow mode each part keeps only its sign. A host loads the gain tables through a simple write port, one word per cycle, while samples keep flowing. Results come out a fixed two cycles after the input, with the channel number alongside.

Top module: `gain_requant`

## Requirements
- R1: `out_valid` is high exactly two clock edges after each edge that samples `in_valid` high, and low otherwise; there is one output per accepted sample.
- R2: `out_chan` equals the `in_chan` of the sample it belongs to.
- R3: A host write (`gw_en`=1, `gw_pol` selecting polarization 0 or 1, `gw_addr` the channel) replaces that channel's gain. Samples accepted on a later edge use the new gain. A sample accepted on the same edge as the write still uses the previous gain.
- R4: The 4-bit code of a part is round(x·g·8). Here x is the signed 24-bit input with 23 fractional bits, and g is the unsigned 32-bit gain with 17 fractional bits.
- R5: Rounding is to the nearest integer code; an exact half-step rounds away from zero.
- R6: 4-bit codes clip to the range -7..+7; the code -8 (4'b1000) is never produced.
- R7: In 4-bit mode, `out_pN[7:4]` is the real code and `out_pN[3:0]` the imaginary code, both two's complement.
- R8: In 1-bit mode (`mode_sel`=0), `out_pN[1]` is 1 when the real product x·g is non-negative and 0 otherwise, and `out_pN[0]` is the same for the imaginary part. A zero product gives 1. Bits 7..2 are 0.
- R9: `mode_sel` is sampled together with each sample. A mode change affects only samples accepted from that edge on.
- R10: While `rst_n` is low and after its release, `out_valid` is low until a sample has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_chan | input | 11 | Channel number of the sample |
| in_p0_re | input | 24 | Polarization 0 real part, signed, 23 fractional bits |
| in_p0_im | input | 24 | Polarization 0 imaginary part |
| in_p1_re | input | 24 | Polarization 1 real part |
| in_p1_im | input | 24 | Polarization 1 imaginary part |
| mode_sel | input | 1 | 1 = 4-bit codes, 0 = sign bits |
| gw_en | input | 1 | Gain table write strobe |
| gw_pol | input | 1 | Gain table select (polarization) |
| gw_addr | input | 11 | Channel to write |
| gw_data | input | 32 | Gain, unsigned, 17 fractional bits |
| out_valid | output | 1 | Output sample present |
| out_chan | output | 11 | Channel number of the output |
| out_p0 | output | 8 | Polarization 0 packed result |
| out_p1 | output | 8 | Polarization 1 packed result |

## Verification
Directed samples at unit and double gain separate plain scaling (R4) from rounding: values sitting exactly on a half step, and one LSB below it, show ties going away from zero and near-ties going down. Full-scale positive and negative values expose a missing clip or a -8 code. Zero and negative inputs in sign mode show the polarity of the sign bit. A gain write issued in the same cycle as a sample on the same channel, then repeated without the write, tells the old gain from the new. A long random stream then mixes channels, gains, magnitudes spread over many octaves, idle cycles and modes that flip from sample to sample. This catches a lost or extra output, a misaligned channel and a mode sampled at the wrong stage.

// File: rtl/gq_pkg.sv
package gq_pkg;
  localparam int NUM_POL = 2;
  typedef enum logic {
    MODE_SIGN = 1'b0,
    MODE_NIB  = 1'b1
  } gq_mode_e;
endpackage

// File: rtl/gq_coef_ram.sv
module gq_coef_ram #(
  parameter int DEPTH = 2048,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  // Non-blocking update: a read on the write edge returns the old word.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/gq_quant.sv
module gq_quant #(
  parameter int DATA_W    = 24,
  parameter int DATA_FRAC = 23,
  parameter int COEF_W    = 32,
  parameter int COEF_FRAC = 17,
  parameter int CODE_W    = 4,
  localparam int CODE_FRAC = CODE_W - 1,
  localparam int SHIFT     = DATA_FRAC + COEF_FRAC - CODE_FRAC,
  localparam int PROD_W    = DATA_W + COEF_W + 1,
  localparam int MAX_CODE  = (1 << (CODE_W - 1)) - 1
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic        [COEF_W-1:0] gain_i,
  output logic        [CODE_W-1:0] code_o,
  output logic                     nonneg_o
);
  logic signed [PROD_W-1:0] prod;
  logic        [PROD_W-1:0] mag;
  logic        [PROD_W-1:0] rounded;
  logic        [CODE_W-1:0] sat_mag;
  logic                     neg;

  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (SHIFT - 1);

  always_comb begin
    prod    = PROD_W'(sample_i) * $signed({1'b0, gain_i});
    neg     = prod[PROD_W-1];
    mag     = neg ? PROD_W'(-prod) : PROD_W'(prod);
    // magnitude rounding gives ties away from zero
    rounded = (mag + HALF) >> SHIFT;
    if (rounded > PROD_W'(MAX_CODE)) sat_mag = CODE_W'(MAX_CODE);
    else                             sat_mag = rounded[CODE_W-1:0];
    code_o   = neg ? CODE_W'(-sat_mag) : sat_mag;
    nonneg_o = ~neg;
  end
endmodule

// File: rtl/gain_requant.sv
module gain_requant
  import gq_pkg::*;
#(
  parameter int NUM_CHAN  = 2048,
  parameter int DATA_W    = 24,
  parameter int DATA_FRAC = 23,
  parameter int COEF_W    = 32,
  parameter int COEF_FRAC = 17,
  parameter int CODE_W    = 4,
  localparam int CHAN_W = $clog2(NUM_CHAN),
  localparam int BYTE_W = 2 * CODE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic        [CHAN_W-1:0] in_chan,
  input  logic signed [DATA_W-1:0] in_p0_re,
  input  logic signed [DATA_W-1:0] in_p0_im,
  input  logic signed [DATA_W-1:0] in_p1_re,
  input  logic signed [DATA_W-1:0] in_p1_im,
  input  logic                     mode_sel,
  input  logic                     gw_en,
  input  logic                     gw_pol,
  input  logic        [CHAN_W-1:0] gw_addr,
  input  logic        [COEF_W-1:0] gw_data,
  output logic                     out_valid,
  output logic        [CHAN_W-1:0] out_chan,
  output logic        [BYTE_W-1:0] out_p0,
  output logic        [BYTE_W-1:0] out_p1
);
  logic signed [DATA_W-1:0] in_re [NUM_POL];
  logic signed [DATA_W-1:0] in_im [NUM_POL];
  assign in_re[0] = in_p0_re;
  assign in_im[0] = in_p0_im;
  assign in_re[1] = in_p1_re;
  assign in_im[1] = in_p1_im;

  // stage 1: sample registers and gain lookup
  logic                     s1_valid_q, s1_valid_d;
  logic [CHAN_W-1:0]        s1_chan_q;
  gq_mode_e                 s1_mode_q;
  logic signed [DATA_W-1:0] s1_re_q [NUM_POL];
  logic signed [DATA_W-1:0] s1_im_q [NUM_POL];
  logic [COEF_W-1:0]        s1_gain [NUM_POL];

  // stage 2: packed results
  logic                     s2_valid_q, s2_valid_d;
  logic [CHAN_W-1:0]        s2_chan_q;
  logic [BYTE_W-1:0]        s2_byte_q [NUM_POL];
  logic [BYTE_W-1:0]        s2_byte_d [NUM_POL];

  genvar p;
  generate
    for (p = 0; p < NUM_POL; p++) begin : g_pol
      logic [CODE_W-1:0] code_re, code_im;
      logic              pos_re, pos_im;

      gq_coef_ram #(.DEPTH(NUM_CHAN), .WIDTH(COEF_W)) u_ram (
        .clk     (clk),
        .wr_en   (gw_en && (gw_pol == 1'(p))),
        .wr_addr (gw_addr),
        .wr_data (gw_data),
        .rd_en   (in_valid),
        .rd_addr (in_chan),
        .rd_data (s1_gain[p])
      );

      always_ff @(posedge clk) begin
        if (in_valid) begin
          s1_re_q[p] <= in_re[p];
          s1_im_q[p] <= in_im[p];
        end
      end

      gq_quant #(
        .DATA_W(DATA_W), .DATA_FRAC(DATA_FRAC), .COEF_W(COEF_W),
        .COEF_FRAC(COEF_FRAC), .CODE_W(CODE_W)
      ) u_q_re (
        .sample_i (s1_re_q[p]),
        .gain_i   (s1_gain[p]),
        .code_o   (code_re),
        .nonneg_o (pos_re)
      );

      gq_quant #(
        .DATA_W(DATA_W), .DATA_FRAC(DATA_FRAC), .COEF_W(COEF_W),
        .COEF_FRAC(COEF_FRAC), .CODE_W(CODE_W)
      ) u_q_im (
        .sample_i (s1_im_q[p]),
        .gain_i   (s1_gain[p]),
        .code_o   (code_im),
        .nonneg_o (pos_im)
      );

      always_comb begin
        if (s1_mode_q == MODE_NIB) s2_byte_d[p] = {code_re, code_im};
        else                       s2_byte_d[p] = {{(BYTE_W-2){1'b0}}, pos_re, pos_im};
      end

      always_ff @(posedge clk) begin
        if (s1_valid_q) s2_byte_q[p] <= s2_byte_d[p];
      end
    end
  endgenerate

  // control next state
  always_comb begin
    s1_valid_d = in_valid;
    s2_valid_d = s1_valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s2_valid_q <= s2_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_chan_q <= in_chan;
      s1_mode_q <= gq_mode_e'(mode_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid_q) s2_chan_q <= s1_chan_q;
  end

  assign out_valid = s2_valid_q;
  assign out_chan  = s2_chan_q;
  assign out_p0    = s2_byte_q[0];
  assign out_p1    = s2_byte_q[1];
endmodule

module gq_checker #(
  parameter int CHAN_W = 11,
  parameter int DATA_W = 24,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CHAN_W-1:0] in_chan,
  input logic [DATA_W-1:0] in_p0_re,
  input logic              mode_sel,
  input logic              out_valid,
  input logic [CHAN_W-1:0] out_chan,
  input logic [BYTE_W-1:0] out_p0,
  input logic [BYTE_W-1:0] out_p1
);
  localparam int NIB = BYTE_W / 2;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid); // R1
  AST_CHAN_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 (out_chan == $past(in_chan, 2))); // R2
  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_p0[BYTE_W-1:NIB] != {1'b1, {(NIB-1){1'b0}}}
               && out_p0[NIB-1:0]       != {1'b1, {(NIB-1){1'b0}}}
               && out_p1[BYTE_W-1:NIB]  != {1'b1, {(NIB-1){1'b0}}}
               && out_p1[NIB-1:0]       != {1'b1, {(NIB-1){1'b0}}})); // R6
  AST_SIGN_MODE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_sel) |-> ##2 (out_p0[BYTE_W-1:2] == '0 && out_p1[BYTE_W-1:2] == '0)); // R8
  AST_ZERO_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel && in_p0_re == '0) |-> ##2 (out_p0[BYTE_W-1:NIB] == '0)); // R4
endmodule

bind gain_requant gq_checker #(.CHAN_W(CHAN_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_chan   (in_chan),
  .in_p0_re  (in_p0_re),
  .mode_sel  (mode_sel),
  .out_valid (out_valid),
  .out_chan  (out_chan),
  .out_p0    (out_p0),
  .out_p1    (out_p1)
);

// File: tb/tb_gain_requant.sv
module tb_gain_requant;
  localparam int NCH = 2048;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [10:0] in_chan;
  logic signed [23:0] in_p0_re, in_p0_im, in_p1_re, in_p1_im;
  logic        mode_sel;
  logic        gw_en, gw_pol;
  logic [10:0] gw_addr;
  logic [31:0] gw_data;
  logic        out_valid;
  logic [10:0] out_chan;
  logic [7:0]  out_p0, out_p1;

  gain_requant dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_p0_re(in_p0_re), .in_p0_im(in_p0_im), .in_p1_re(in_p1_re), .in_p1_im(in_p1_im),
    .mode_sel(mode_sel), .gw_en(gw_en), .gw_pol(gw_pol), .gw_addr(gw_addr),
    .gw_data(gw_data), .out_valid(out_valid), .out_chan(out_chan),
    .out_p0(out_p0), .out_p1(out_p1)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int unsigned gmodel [2][NCH];

  // two-deep expectation pipe
  bit          ev   [2];
  logic [10:0] ech  [2];
  logic [7:0]  eb0  [2];
  logic [7:0]  eb1  [2];
  string       etag [2];

  function automatic logic [3:0] ref_code(int x, int unsigned g);
    longint p, m, r;
    p = longint'(x) * longint'(g);
    m = (p < 0) ? -p : p;
    r = (m + (longint'(1) <<< 36)) >>> 37;
    if (r > 7) r = 7;
    if (p < 0) r = -r;
    return r[3:0];
  endfunction

  function automatic logic ref_pos(int x, int unsigned g);
    longint p;
    p = longint'(x) * longint'(g);
    return p >= 0;
  endfunction

  function automatic logic [7:0] ref_byte(int re, int im, int unsigned g, logic m4);
    if (m4) return {ref_code(re, g), ref_code(im, g)};
    return {6'b0, ref_pos(re, g), ref_pos(im, g)};
  endfunction

  task automatic compare();
    checks++;
    if (ev[1]) begin
      if (out_valid !== 1'b1 || out_chan !== ech[1] || out_p0 !== eb0[1] || out_p1 !== eb1[1]) begin
        errors++;
        $display("FAIL %s: got v=%b ch=%0d p0=%h p1=%h expected v=1 ch=%0d p0=%h p1=%h",
                 etag[1], out_valid, out_chan, out_p0, out_p1, ech[1], eb0[1], eb1[1]);
      end
    end else if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: got out_valid=%b expected 0", out_valid);
    end
  endtask

  // One cycle: check the output, drive the next inputs, update the models.
  task automatic step(bit v, int ch, int a, int b, int c, int d, bit m4,
                      bit we, bit wp, int wa, int unsigned wd, string tag);
    @(negedge clk);
    compare();
    ev[1] = ev[0]; ech[1] = ech[0]; eb0[1] = eb0[0]; eb1[1] = eb1[0]; etag[1] = etag[0];
    in_valid = v; in_chan = 11'(ch);
    in_p0_re = 24'(a); in_p0_im = 24'(b); in_p1_re = 24'(c); in_p1_im = 24'(d);
    mode_sel = m4;
    gw_en = we; gw_pol = wp; gw_addr = 11'(wa); gw_data = wd;
    ev[0] = v; ech[0] = 11'(ch); etag[0] = tag;
    eb0[0] = ref_byte(a, b, gmodel[0][ch], m4);
    eb1[0] = ref_byte(c, d, gmodel[1][ch], m4);
    if (we) gmodel[wp][wa] = wd;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R1");
  endtask

  function automatic int rnd_sample();
    int x;
    x = int'($urandom_range(0, 32'h00FF_FFFF));
    x = (x <<< 8) >>> 8;
    return x >>> $urandom_range(0, 14);
  endfunction

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_1234);
    for (int i = 0; i < 2; i++) begin
      ev[i] = 0; ech[i] = 0; eb0[i] = 0; eb1[i] = 0; etag[i] = "R1";
    end
    rst_n = 0; in_valid = 0; in_chan = 0; mode_sel = 1;
    in_p0_re = 0; in_p0_im = 0; in_p1_re = 0; in_p1_im = 0;
    gw_en = 0; gw_pol = 0; gw_addr = 0; gw_data = 0;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R10: got out_valid=%b in reset expected 0", out_valid);
      end
    end
    rst_n = 1;

    // load both tables (R3)
    for (int pol = 0; pol < 2; pol++)
      for (int ch = 0; ch < NCH; ch++)
        step(0, 0, 0, 0, 0, 0, 1, 1, pol[0], ch, $urandom_range(0, 32'h0020_0000), "R10");

    // unit gain on channel 5 pol 0, double gain on pol 1
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 5, 32'h0002_0000, "R3");
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, 5, 32'h0004_0000, "R3");
    // R4 / R7: 0.5 -> +4, -0.25 -> -2 ; doubled on pol 1
    step(1, 5, 1 << 22, -(1 << 21), 1 << 20, -(1 << 19), 1, 0, 0, 0, 0, "R4 R7");
    // R5: exact half steps and one below
    step(1, 5, 1 << 19, -(1 << 19), (1 << 18), -(1 << 18), 1, 0, 0, 0, 0, "R5 tie");
    step(1, 5, (1 << 19) - 1, -((1 << 19) - 1), 3 << 18, -(3 << 18), 1, 0, 0, 0, 0, "R5 near");
    // R6: full scale both signs
    step(1, 5, 32'h007F_FFFF, -(1 << 23), 32'h007F_FFFF, -(1 << 23), 1, 0, 0, 0, 0, "R6");
    step(1, 5, 7 << 20, -(15 << 19), 3 << 19, -(1 << 22), 1, 0, 0, 0, 0, "R6 edge");
    // R8: sign mode, zero counts as non-negative
    step(1, 5, 0, -1, 100, -(1 << 23), 0, 0, 0, 0, 0, "R8");
    step(1, 5, -5, 0, 0, 7, 0, 0, 0, 0, 0, "R8 zero");
    // R9: mode flips every sample
    for (int k = 0; k < 6; k++)
      step(1, 5, (k + 1) << 19, -(k << 19), -(k << 18), k << 20, k[0], 0, 0, 0, 0, "R9");
    // R3: write in the same cycle as a sample on channel 9, then again after
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 9, 32'h0001_0000, "R3");
    step(1, 9, 1 << 22, 1 << 22, 1 << 21, 0, 1, 1, 0, 9, 32'h0003_0000, "R3 old");
    step(1, 9, 1 << 22, 1 << 22, 1 << 21, 0, 1, 0, 0, 0, 0, "R3 new");
    // R2: back-to-back channels
    for (int k = 0; k < 8; k++)
      step(1, 2047 - k, 1 << 20, 1 << 20, 0, 0, 1, 0, 0, 0, 0, "R2");
    idle();

    // random stream
    for (int n = 0; n < 6000; n++) begin
      bit v, m, we;
      v  = ($urandom_range(0, 9) < 7);
      m  = $urandom_range(0, 1);
      we = ($urandom_range(0, 9) == 0);
      step(v, $urandom_range(0, NCH - 1), rnd_sample(), rnd_sample(), rnd_sample(), rnd_sample(),
           m, we, $urandom_range(0, 1), $urandom_range(0, NCH - 1),
           $urandom_range(0, 32'h0040_0000), m ? "R4 R6 random" : "R8 random");
    end
    idle(); idle(); idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule